// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare

This peripheral keeps a 16-bit up-counter that advances on ticks from a prescaler. The prescaler divides the system clock by an amount picked in control register B. The counter can run freely and wrap, or it can return to zero when it reaches a top value. The top value comes from compare register A or from the capture register, depending on the mode. Three compare registers raise their own flags when the count reaches them. Overflow and capture each have a flag too. Each interrupt line is its flag gated by a mask bit.

A host reaches the block over a byte-wide bus with three selects. The main select addresses a 14-byte window. The other two selects each address one byte: the mask register and the flag register. The counter and capture registers are 16 bits wide, but the bus is one byte wide. To move a 16-bit value in one piece, they share a single holding byte. Reading the low byte snapshots the high byte into the holding byte. Writing the low byte commits the whole 16-bit value.

The counter core is a small state machine with four states. ST_IDLE means the clock select is stopped. ST_NORMAL is free counting with wrap. ST_CLR_A clears on compare A. ST_CLR_CAP clears on the capture register. On every clock edge the next state is taken from the control bits. A stopped clock select leads to ST_IDLE. Otherwise mode code 4 leads to ST_CLR_A, code 12 leads to ST_CLR_CAP, and every other code leads to ST_NORMAL. Any state can move to any other on one edge. Because of this state register, a control change takes effect one edge after it is written.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the counter, all registers, the mask and the flags read 0, and all five interrupt outputs are low.
- R2: Clock-select field control B[2:0] codes: 0, 6 and 7 stop the counter. Codes 1 to 5 divide by 1, 8, 64, 256 and 1024. Writing control B restarts the prescaler. For division N, the first increment lands on edge max(N,2) after the edge that captures the write.
- R3: Main window byte offsets: 0 ctrl A, 1 ctrl B, 2 ctrl C, 3 reserved (reads 0), 4/5 counter low/high, 6/7 capture low/high, 8/9 compare A, 10/11 compare B, 12/13 compare C. A write to offset 5 or 7 goes only to the holding byte. A write to offset 4 or 6 loads {holding byte, data} into the 16-bit register.
- R4: A read of offset 4 or 6 returns the low byte and copies that register's high byte into the holding byte. A read of offset 5 or 7 returns the holding byte.
- R5: In normal state, a tick at count 0xFFFF wraps the count to 0 and sets overflow flag bit 0.
- R6: A tick while running with count equal to compare A, B or C sets flag bit 1, 2 or 3. The flag is visible one edge later.
- R7: The mode code is {ctrl B[4:3], ctrl A[1:0]}. Code 4 clears the counter on the tick where it equals compare A.
- R8: Code 12 clears the counter on the tick where it equals the capture register, and sets capture flag bit 5.
- R9: Mode codes other than 4 and 12 count as normal mode and do not clear at compare A.
- R10: Flags are set whatever the mask holds. Each interrupt output is its flag AND the matching mask bit (same bit numbers).
- R11: Writing the flag byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R12: The compare registers are written and read byte by byte, directly, without the holding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_main | input | 1 | Selects the 14-byte main window |
| bus_sel_mask | input | 1 | Selects the interrupt mask byte |
| bus_sel_flag | input | 1 | Selects the interrupt flag byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on the holding byte) |
| bus_addr | input | 4 | Byte offset within the main window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current selects and address |
| irq_capture | output | 1 | Capture interrupt |
| irq_cmp_a | output | 1 | Compare A interrupt |
| irq_cmp_b | output | 1 | Compare B interrupt |
| irq_cmp_c | output | 1 | Compare C interrupt |
| irq_overflow | output | 1 | Overflow interrupt |

## Verification
Let edge E0 be the one that captures a control B write. With divide-by-1, the counter first moves on E2, because the state register absorbs E1. It then moves one step per edge. With divide-by-8 it first moves on E8. A flag, and its interrupt output, becomes visible on the edge after the tick on which the count matched. The bench drives each access on a falling edge. It then counts exactly that many falling edges, so the count and the flags are sampled in the one cycle where the new value must have just appeared. It also samples the cycle before, where the old value must still hold. Reads return data in the same cycle, so each read samples the exact count present at its falling edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int CS_W   = 3;
    localparam int MODE_W = 4;

    localparam logic [3:0] OFS_CTLA   = 4'd0;
    localparam logic [3:0] OFS_CTLB   = 4'd1;
    localparam logic [3:0] OFS_CTLC   = 4'd2;
    localparam logic [3:0] OFS_CNT_LO = 4'd4;
    localparam logic [3:0] OFS_CNT_HI = 4'd5;
    localparam logic [3:0] OFS_CAP_LO = 4'd6;
    localparam logic [3:0] OFS_CAP_HI = 4'd7;
    localparam logic [3:0] OFS_CMA_LO = 4'd8;
    localparam logic [3:0] OFS_CMA_HI = 4'd9;
    localparam logic [3:0] OFS_CMB_LO = 4'd10;
    localparam logic [3:0] OFS_CMB_HI = 4'd11;
    localparam logic [3:0] OFS_CMC_LO = 4'd12;
    localparam logic [3:0] OFS_CMC_HI = 4'd13;

    localparam int FB_OVF  = 0;
    localparam int FB_CMPA = 1;
    localparam int FB_CMPB = 2;
    localparam int FB_CMPC = 3;
    localparam int FB_CAP  = 5;
    localparam logic [BYTE_W-1:0] FLAG_USED = 8'h2F;

    localparam logic [MODE_W-1:0] MODE_CLR_A   = 4'd4;
    localparam logic [MODE_W-1:0] MODE_CLR_CAP = 4'd12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORMAL,
        ST_CLR_A,
        ST_CLR_CAP
    } tmr_state_e;

    typedef struct packed {
        logic ovf;
        logic cmpa;
        logic cmpb;
        logic cmpc;
        logic cap;
    } tmr_ev_t;
endpackage

// File: rtl/tmr16_presc.sv
module tmr16_presc
    import tmr16_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] clk_sel,
    input  logic            restart,
    output logic            tick,
    output logic            running
);
    logic [DIV_W-1:0] presc_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        running = 1'b1;
        limit   = '0;
        unique case (clk_sel)
            3'd1:    limit = DIV_W'(0);
            3'd2:    limit = DIV_W'(7);
            3'd3:    limit = DIV_W'(63);
            3'd4:    limit = DIV_W'(255);
            3'd5:    limit = DIV_W'(1023);
            default: running = 1'b0;
        endcase
    end

    assign tick = running && (presc_q == limit) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            presc_q <= '0;
        else if (restart || !running || tick)
            presc_q <= '0;
        else
            presc_q <= presc_q + 1'b1;
    end

    p_presc_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (presc_q == '0));
    p_stopped_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 || clk_sel == 3'd6 || clk_sel == 3'd7) |-> !tick);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              running,
    input  logic [MODE_W-1:0] mode,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  top_a,
    input  logic [CNT_W-1:0]  top_cap,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic [CNT_W-1:0]  cmp_c,
    output logic [CNT_W-1:0]  cnt_q,
    output tmr_ev_t           ev
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             step;

    always_comb begin
        if (!running)
            state_d = ST_IDLE;
        else if (mode == MODE_CLR_A)
            state_d = ST_CLR_A;
        else if (mode == MODE_CLR_CAP)
            state_d = ST_CLR_CAP;
        else
            state_d = ST_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign step = tick && !load_en && (state_q != ST_IDLE);

    always_comb begin
        cnt_d = cnt_q;
        ev    = '0;
        if (load_en) begin
            cnt_d = load_val;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: cnt_d = cnt_q;
                ST_NORMAL: begin
                    cnt_d  = cnt_q + 1'b1;
                    ev.ovf = (cnt_q == '1);
                end
                ST_CLR_A: begin
                    cnt_d  = (cnt_q == top_a) ? '0 : cnt_q + 1'b1;
                    ev.ovf = (cnt_q == '1) && (cnt_q != top_a);
                end
                ST_CLR_CAP: begin
                    cnt_d  = (cnt_q == top_cap) ? '0 : cnt_q + 1'b1;
                    ev.ovf = (cnt_q == '1) && (cnt_q != top_cap);
                    ev.cap = (cnt_q == top_cap);
                end
            endcase
        end
        if (step) begin
            ev.cmpa = (cnt_q == top_a);
            ev.cmpb = (cnt_q == cmp_b);
            ev.cmpc = (cnt_q == cmp_c);
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(cnt_q));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && tick && !load_en && cnt_q == '1) |=> (cnt_q == '0));
    p_clr_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR_A && tick && !load_en && cnt_q == top_a) |=> (cnt_q == '0));
    p_clr_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR_CAP && tick && !load_en && cnt_q == top_cap) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_main,
    input  logic        bus_sel_mask,
    input  logic        bus_sel_flag,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_capture,
    output logic        irq_cmp_a,
    output logic        irq_cmp_b,
    output logic        irq_cmp_c,
    output logic        irq_overflow
);
    logic [BYTE_W-1:0] ctla_q, ctlb_q, ctlc_q, tmp_q, mask_q, flags_q, flags_set;
    logic [CNT_W-1:0]  icr_q, ocra_q, ocrb_q, ocrc_q, cnt_q;
    logic              main_wr, main_rd, cnt_load, restart, tick, running;
    tmr_ev_t           ev;

    assign main_wr  = bus_sel_main && bus_wr;
    assign main_rd  = bus_sel_main && bus_rd;
    assign cnt_load = main_wr && (bus_addr == OFS_CNT_LO);
    assign restart  = main_wr && (bus_addr == OFS_CTLB);

    tmr16_presc #(.DIV_W(DIV_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(ctlb_q[CS_W-1:0]),
        .restart(restart), .tick(tick), .running(running)
    );

    tmr16_core core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
        .mode({ctlb_q[4:3], ctla_q[1:0]}), .load_en(cnt_load),
        .load_val({tmp_q, bus_wdata}), .top_a(ocra_q), .top_cap(icr_q),
        .cmp_b(ocrb_q), .cmp_c(ocrc_q), .cnt_q(cnt_q), .ev(ev)
    );

    always_comb begin
        flags_set          = '0;
        flags_set[FB_OVF]  = ev.ovf;
        flags_set[FB_CMPA] = ev.cmpa;
        flags_set[FB_CMPB] = ev.cmpb;
        flags_set[FB_CMPC] = ev.cmpc;
        flags_set[FB_CAP]  = ev.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctla_q <= '0; ctlb_q <= '0; ctlc_q <= '0; tmp_q <= '0;
            mask_q <= '0; flags_q <= '0;
            icr_q <= '0; ocra_q <= '0; ocrb_q <= '0; ocrc_q <= '0;
        end else begin
            flags_q <= ((bus_sel_flag && bus_wr) ? (flags_q & ~bus_wdata) : flags_q)
                       | (flags_set & FLAG_USED);
            if (bus_sel_mask && bus_wr)
                mask_q <= bus_wdata;
            if (main_rd && bus_addr == OFS_CNT_LO)
                tmp_q <= cnt_q[15:8];
            if (main_rd && bus_addr == OFS_CAP_LO)
                tmp_q <= icr_q[15:8];
            if (main_wr) begin
                case (bus_addr)
                    OFS_CTLA:   ctla_q <= bus_wdata;
                    OFS_CTLB:   ctlb_q <= bus_wdata;
                    OFS_CTLC:   ctlc_q <= bus_wdata;
                    OFS_CNT_HI: tmp_q  <= bus_wdata;
                    OFS_CAP_HI: tmp_q  <= bus_wdata;
                    OFS_CAP_LO: icr_q  <= {tmp_q, bus_wdata};
                    OFS_CMA_LO: ocra_q[7:0]  <= bus_wdata;
                    OFS_CMA_HI: ocra_q[15:8] <= bus_wdata;
                    OFS_CMB_LO: ocrb_q[7:0]  <= bus_wdata;
                    OFS_CMB_HI: ocrb_q[15:8] <= bus_wdata;
                    OFS_CMC_LO: ocrc_q[7:0]  <= bus_wdata;
                    OFS_CMC_HI: ocrc_q[15:8] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel_mask)
            bus_rdata = mask_q;
        else if (bus_sel_flag)
            bus_rdata = flags_q;
        else if (bus_sel_main) begin
            case (bus_addr)
                OFS_CTLA:   bus_rdata = ctla_q;
                OFS_CTLB:   bus_rdata = ctlb_q;
                OFS_CTLC:   bus_rdata = ctlc_q;
                OFS_CNT_LO: bus_rdata = cnt_q[7:0];
                OFS_CNT_HI: bus_rdata = tmp_q;
                OFS_CAP_LO: bus_rdata = icr_q[7:0];
                OFS_CAP_HI: bus_rdata = tmp_q;
                OFS_CMA_LO: bus_rdata = ocra_q[7:0];
                OFS_CMA_HI: bus_rdata = ocra_q[15:8];
                OFS_CMB_LO: bus_rdata = ocrb_q[7:0];
                OFS_CMB_HI: bus_rdata = ocrb_q[15:8];
                OFS_CMC_LO: bus_rdata = ocrc_q[7:0];
                OFS_CMC_HI: bus_rdata = ocrc_q[15:8];
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_overflow = flags_q[FB_OVF]  & mask_q[FB_OVF];
    assign irq_cmp_a    = flags_q[FB_CMPA] & mask_q[FB_CMPA];
    assign irq_cmp_b    = flags_q[FB_CMPB] & mask_q[FB_CMPB];
    assign irq_cmp_c    = flags_q[FB_CMPC] & mask_q[FB_CMPC];
    assign irq_capture  = flags_q[FB_CAP]  & mask_q[FB_CAP];

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_flag && bus_wr && bus_wdata[FB_OVF] && !ev.ovf) |=> !flags_q[FB_OVF]);
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FB_CMPB] && !(bus_sel_flag && bus_wr)) |=> flags_q[FB_CMPB]);
    p_tmp_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd && bus_addr == OFS_CNT_LO) |=> (tmp_q == $past(cnt_q[15:8])));
    p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && bus_addr == OFS_CNT_HI) |=> $stable(cnt_q) || $past(tick));
endmodule

// File: tb/tmr16_unit_tb.sv
`timescale 1ns/1ps
module tmr16_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_main = 0, sel_mask = 0, sel_flag = 0, wr = 0, rd = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq_cap, irq_a, irq_b, irq_c, irq_ovf;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr16_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_main(sel_main), .bus_sel_mask(sel_mask),
        .bus_sel_flag(sel_flag), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_capture(irq_cap),
        .irq_cmp_a(irq_a), .irq_cmp_b(irq_b), .irq_cmp_c(irq_c), .irq_overflow(irq_ovf)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // space: 0 main, 1 mask, 2 flag. Called at a falling edge, returns at the next.
    task automatic bw(input int space, input logic [3:0] a, input logic [7:0] d);
        sel_main = (space == 0); sel_mask = (space == 1); sel_flag = (space == 2);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; sel_main = 0; sel_mask = 0; sel_flag = 0;
    endtask

    task automatic br(input int space, input logic [3:0] a, output logic [7:0] d);
        sel_main = (space == 0); sel_mask = (space == 1); sel_flag = (space == 2);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; sel_main = 0; sel_mask = 0; sel_flag = 0;
    endtask

    task automatic set16(input logic [3:0] lo, input logic [15:0] v);
        bw(0, lo + 4'd1, v[15:8]);
        bw(0, lo, v[7:0]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 irq lines", {irq_cap, irq_a, irq_b, irq_c, irq_ovf}, 0);
        br(0, 4'd4, d); check("R1 count low", d, 0);
        br(0, 4'd5, d); check("R1 count high", d, 0);
        br(0, 4'd1, d); check("R1 ctrl B", d, 0);
        br(1, 4'd0, d); check("R1 mask", d, 0);
        br(2, 4'd0, d); check("R1 flags", d, 0);
    endtask

    task automatic t_div8;
        logic [7:0] d;
        bw(0, 4'd1, 8'h02);
        repeat (7) @(negedge clk);
        br(0, 4'd4, d); check("R2 div8 before 8th edge", d, 0);
        br(0, 4'd4, d); check("R2 div8 on 8th edge", d, 1);
        bw(0, 4'd1, 8'h06);
        repeat (20) @(negedge clk);
        br(0, 4'd4, d); check("R2 code 6 stopped", d, 1);
        bw(0, 4'd1, 8'h00);
    endtask

    task automatic t_wr16;
        logic [7:0] d;
        set16(4'd4, 16'h1234);
        br(0, 4'd4, d); check("R3 count low", d, 8'h34);
        br(0, 4'd5, d); check("R3 count high", d, 8'h12);
        bw(0, 4'd5, 8'h77);
        br(0, 4'd4, d); check("R3 high write alone low", d, 8'h34);
        br(0, 4'd5, d); check("R3 high write alone high", d, 8'h12);
        br(0, 4'd3, d); check("R3 reserved", d, 0);
        set16(4'd6, 16'h1A2B);
        br(0, 4'd6, d); check("R4 capture low", d, 8'h2B);
        br(0, 4'd7, d); check("R4 capture high", d, 8'h1A);
    endtask

    task automatic t_atomic_rd;
        logic [7:0] lo, hi;
        set16(4'd4, 16'h00FA);
        bw(0, 4'd1, 8'h01);
        repeat (6) @(negedge clk);
        br(0, 4'd4, lo);
        br(0, 4'd5, hi);
        check("R4 snapshot across carry", {hi, lo}, 16'h00FF);
        bw(0, 4'd1, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        bw(2, 4'd0, 8'hFF);
        set16(4'd8, 16'h8000); set16(4'd10, 16'h8000); set16(4'd12, 16'h8000);
        bw(1, 4'd0, 8'h01);
        set16(4'd4, 16'hFFFE);
        bw(0, 4'd1, 8'h01);
        repeat (2) @(negedge clk);
        check("R5 no overflow before wrap", irq_ovf, 0);
        @(negedge clk);
        check("R10 overflow irq", irq_ovf, 1);
        br(2, 4'd0, d); check("R5 overflow flag", d, 8'h01);
        bw(0, 4'd1, 8'h00);
        bw(2, 4'd0, 8'h00);
        br(2, 4'd0, d); check("R11 zero write keeps flag", d, 8'h01);
        bw(2, 4'd0, 8'h01);
        br(2, 4'd0, d); check("R11 one write clears flag", d, 0);
        check("R11 irq low after clear", irq_ovf, 0);
    endtask

    task automatic t_compare;
        logic [7:0] d;
        bw(1, 4'd0, 8'h00);
        bw(2, 4'd0, 8'hFF);
        set16(4'd8, 16'h0040); set16(4'd10, 16'h0005); set16(4'd12, 16'h0006);
        br(0, 4'd9, d); check("R12 compare A high", d, 8'h00);
        br(0, 4'd11, d); check("R12 compare B high", d, 8'h00);
        br(0, 4'd10, d); check("R12 compare B low", d, 8'h05);
        set16(4'd4, 16'h0000);
        bw(0, 4'd1, 8'h01);
        repeat (6) @(negedge clk);
        br(2, 4'd0, d); check("R6 no flag before match", d, 0);
        br(2, 4'd0, d); check("R6 compare B flag", d, 8'h04);
        br(2, 4'd0, d); check("R6 compare C flag", d, 8'h0C);
        check("R10 masked irq stays low", irq_b, 0);
        bw(0, 4'd1, 8'h00);
        bw(1, 4'd0, 8'h04);
        check("R10 irq follows mask", irq_b, 1);
        check("R10 unmasked C low", irq_c, 0);
    endtask

    task automatic t_clr_a;
        logic [7:0] d;
        bw(2, 4'd0, 8'hFF);
        set16(4'd8, 16'h0003);
        set16(4'd4, 16'h0000);
        bw(0, 4'd1, 8'h09);
        repeat (4) @(negedge clk);
        br(0, 4'd4, d); check("R7 count at top", d, 3);
        br(0, 4'd4, d); check("R7 cleared at compare A", d, 0);
        br(2, 4'd0, d); check("R7 compare A flag only", d, 8'h02);
        bw(0, 4'd1, 8'h00);
    endtask

    task automatic t_clr_cap;
        logic [7:0] d;
        bw(2, 4'd0, 8'hFF);
        bw(1, 4'd0, 8'h20);
        set16(4'd4, 16'h0000);
        set16(4'd6, 16'h0002);
        check("R8 capture irq low at start", irq_cap, 0);
        bw(0, 4'd1, 8'h19);
        repeat (3) @(negedge clk);
        br(0, 4'd4, d); check("R8 count at capture top", d, 2);
        br(0, 4'd4, d); check("R8 cleared at capture", d, 0);
        br(2, 4'd0, d); check("R8 capture flag", d, 8'h20);
        check("R8 capture irq", irq_cap, 1);
        bw(0, 4'd1, 8'h00);
    endtask

    task automatic t_other_mode;
        logic [7:0] d;
        bw(2, 4'd0, 8'hFF);
        bw(0, 4'd0, 8'h01);
        set16(4'd4, 16'h0000);
        bw(0, 4'd1, 8'h01);
        repeat (6) @(negedge clk);
        br(0, 4'd4, d); check("R9 mode 1 passes compare A", d, 5);
        bw(0, 4'd1, 8'h00);
        bw(0, 4'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div8();
        t_wr16();
        t_atomic_rd();
        t_overflow();
        t_compare();
        t_clr_a();
        t_clr_cap();
        t_other_mode();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule